// File: doc/BRIEF.md
# Host Command Mailbox Controller

This block sits between an 8-bit host bus and a management processor. The host loads command bytes into a command buffer and starts the command with a control write. The processor reads the command, then answers through two byte queues: response data and status data. It also moves a two-bit protocol state. The host polls a status byte, drains the queues through two read-only registers, and closes the exchange with a data-accept write. That write also empties both queues.

Several other functions share the control register:
- an abort handshake that the processor must acknowledge;
- a sticky error for commands started outside idle;
- an optional completion interrupt, which also shows in bit 7 of the identification byte;
- two DMA request flags, latched when a command starts and released when the exchange returns to idle.

The response and status queues take bytes from the processor over valid/ready. A byte moves on a cycle where valid and ready are both high. Ready is low when the queue is full. Ready is also low during a host write that empties the queues. A producer holds valid and data until it sees ready.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset:
  - the status byte reads 0x00 and the identification byte reads 0xC9;
  - `irq_n` is high and both queue ready outputs are high;
  - `cmd_pending`, `abort_pending`, `dma_now` and `dma_trig` are low.
- R2: Host addresses are 0 identification, 1 control (write) or status (read), 2 command byte (write only), 3 response byte, and 4 status byte. The identification byte reads 0xC9, or 0x49 (bit 7 clear) while the interrupt is active.
- R3: Command bytes written to address 2 in the idle state are stored at offsets 0, 1, 2 and so on, and `cmd_count` reports how many were stored. Bytes beyond 256, and bytes written outside idle, are dropped.
- R4: A control write with bit 0 set in the idle state moves the state to 01 (command busy). The status byte then shows bit 0 set, and `cmd_pending` is high.
- R5: A control write with bit 0 set outside idle leaves the state unchanged and sets status bit 3. That bit stays set until a control write with bit 3 set. If one write carries both bits, the error is set.
- R6: The processor sets the state through `state_we`/`state_val`; it appears in status bits 5:4 (00 idle, 01 busy, 10 data last, 11 data more). A change into idle from any other state does three things:
  - clears `cmd_count`;
  - clears status bit 1;
  - clears both DMA flags.
- R7: Each queue accepts processor bytes on valid and ready and returns them to the host in order; a host read of address 3 or 4 removes one byte. Status bit 7 (response) and bit 6 (status) show that a queue is not empty. Reading an empty queue returns 0x00. Ready is low while a queue is full.
- R8: A control write with bit 1 set in state 10 or 11 sets status bit 1 and empties both queues. Ready is low in that same cycle. In states 00 and 01 the write has no effect.
- R9: A control write with bit 2 set sets status bit 2 and `abort_pending`. When `abort_ack` arrives while the abort is pending, the pending flag clears and the state is forced to idle.
- R10: Control bit 5 loads the interrupt enable on every control write. The enable clears on any host read of address 3 or 4, and on any control write with bit 1 set. `irq_n` goes low when the state enters 10 or 11 from 00 or 01 while the enable is set. It stays low until the enable clears.
- R11: A control write with bit 0 set that starts a command latches bit 7 into `dma_now` and bit 6 into `dma_trig`.
- R12: Host reads of address 2 and of addresses 5 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe; removes one byte on addresses 3 and 4 |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr`, combinational |
| irq_n | output | 1 | Completion interrupt, active low |
| cmd_raddr | input | 8 | Processor read offset into the command buffer |
| cmd_rdata | output | 8 | Command byte at `cmd_raddr` |
| cmd_count | output | 9 | Number of command bytes stored |
| cmd_pending | output | 1 | State is command busy |
| abort_pending | output | 1 | Abort requested and not yet acknowledged |
| rsp_valid | input | 1 | Processor offers a response byte |
| rsp_data | input | 8 | Response byte |
| rsp_ready | output | 1 | Response queue takes the byte |
| sts_valid | input | 1 | Processor offers a status byte |
| sts_data | input | 8 | Status byte |
| sts_ready | output | 1 | Status queue takes the byte |
| state_we | input | 1 | Processor writes the protocol state |
| state_val | input | 2 | New protocol state |
| abort_ack | input | 1 | Processor has serviced the abort |
| dma_now | output | 1 | Immediate DMA requested by the running command |
| dma_trig | output | 1 | Trigger-mode DMA armed by the running command |

## Verification
The queue flush from a data-accept write can land in the same cycle as a processor push into the response queue. The bench provokes this by holding `rsp_valid` high with a fresh byte across the accept write. It judges the result at the ports:
- ready must be low in the accept cycle and high in the next one;
- afterwards exactly that byte must be readable, followed by 0x00.

A second overlap is a start with an error clear in the same write outside idle; the error bit must end up set.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_LAST = 2'b10,
    ST_MORE = 2'b11
  } mbx_state_e;

  localparam logic [2:0] ADR_ID   = 3'd0;
  localparam logic [2:0] ADR_CTRL = 3'd1;
  localparam logic [2:0] ADR_CMD  = 3'd2;
  localparam logic [2:0] ADR_RSP  = 3'd3;
  localparam logic [2:0] ADR_STS  = 3'd4;

  localparam int B_PUSH  = 0;
  localparam int B_ACC   = 1;
  localparam int B_ABORT = 2;
  localparam int B_CLR   = 3;
  localparam int B_IEN   = 5;
  localparam int B_TRIG  = 6;
  localparam int B_DMA   = 7;
endpackage

// File: rtl/mbx_byte_fifo.sv
module mbx_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  input  logic          pop,
  input  logic          flush,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop, empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count == '0);
  assign in_ready = (count != CW'(DEPTH)) && !flush;
  assign do_push  = in_valid && in_ready;
  assign do_pop   = pop && !empty && !flush;
  assign head     = empty ? '0 : mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= in_data;
  end
endmodule

// File: rtl/mbx_cmd_buffer.sv
module mbx_cmd_buffer #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          clear,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count
);
  logic [7:0] mem [DEPTH];
  logic       full, do_wr;

  assign full    = (count == CW'(DEPTH));
  assign do_wr   = wr_en && !full && !clear;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (do_wr) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[count[AW-1:0]] <= wr_data;
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import cmd_mailbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       q_read,
  input  logic       state_we,
  input  logic [1:0] state_val,
  input  logic       abort_ack,
  output mbx_state_e state_q,
  output logic       err_q,
  output logic       abort_q,
  output logic       dacc_q,
  output logic       ien_q,
  output logic       irq_q,
  output logic       dma_now_q,
  output logic       dma_trig_q,
  output logic       flush,
  output logic       going_idle
);
  mbx_state_e state_d;
  logic push, push_ok, acc, ien_d, irq_d, enter_data;
  logic unused_bit4;

  assign unused_bit4 = ctrl_wdata[4];

  always_comb begin
    push    = ctrl_wr && ctrl_wdata[B_PUSH];
    push_ok = push && (state_q == ST_IDLE);
    acc     = ctrl_wr && ctrl_wdata[B_ACC];
    flush   = acc && state_q[1];

    state_d = state_q;
    if (push_ok)               state_d = ST_BUSY;
    if (state_we)              state_d = mbx_state_e'(state_val);
    if (abort_ack && abort_q)  state_d = ST_IDLE;
    going_idle = (state_q != ST_IDLE) && (state_d == ST_IDLE);
    enter_data = state_d[1] && !state_q[1];

    ien_d = ien_q;
    if (ctrl_wr)       ien_d = ctrl_wdata[B_IEN];
    if (acc || q_read) ien_d = 1'b0;
    irq_d = ien_d && (irq_q || enter_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      err_q      <= 1'b0;
      abort_q    <= 1'b0;
      dacc_q     <= 1'b0;
      ien_q      <= 1'b0;
      irq_q      <= 1'b0;
      dma_now_q  <= 1'b0;
      dma_trig_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ien_q   <= ien_d;
      irq_q   <= irq_d;

      if (ctrl_wr && ctrl_wdata[B_CLR]) err_q <= 1'b0;
      if (push && !push_ok)             err_q <= 1'b1;

      if (abort_ack)                      abort_q <= 1'b0;
      if (ctrl_wr && ctrl_wdata[B_ABORT]) abort_q <= 1'b1;

      if (flush)      dacc_q <= 1'b1;
      if (going_idle) dacc_q <= 1'b0;

      if (push_ok) begin
        dma_now_q  <= ctrl_wdata[B_DMA];
        dma_trig_q <= ctrl_wdata[B_TRIG];
      end
      if (going_idle) begin
        dma_now_q  <= 1'b0;
        dma_trig_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmd_mailbox_pkg::*;
#(
  parameter int           CMD_DEPTH = 256,
  parameter int           RSP_DEPTH = 16,
  parameter int           STS_DEPTH = 16,
  parameter logic [7:0]   ID_BYTE   = 8'hC9,
  localparam int          CMD_AW    = $clog2(CMD_DEPTH),
  localparam int          RSP_CW    = $clog2(RSP_DEPTH + 1),
  localparam int          STS_CW    = $clog2(STS_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              irq_n,
  input  logic [CMD_AW-1:0] cmd_raddr,
  output logic [7:0]        cmd_rdata,
  output logic [CMD_AW:0]   cmd_count,
  output logic              cmd_pending,
  output logic              abort_pending,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic              rsp_ready,
  input  logic              sts_valid,
  input  logic [7:0]        sts_data,
  output logic              sts_ready,
  input  logic              state_we,
  input  logic [1:0]        state_val,
  input  logic              abort_ack,
  output logic              dma_now,
  output logic              dma_trig
);
  mbx_state_e        state_q;
  logic              err_q, abort_q, dacc_q, ien_q, irq_q;
  logic              flush, going_idle;
  logic              ctrl_wr, cmd_wr, rsp_pop, sts_pop;
  logic [7:0]        rsp_head, sts_head, status_byte;
  logic [RSP_CW-1:0] rsp_cnt;
  logic [STS_CW-1:0] sts_cnt;

  assign ctrl_wr = host_wr && (host_addr == ADR_CTRL);
  assign cmd_wr  = host_wr && (host_addr == ADR_CMD) && (state_q == ST_IDLE);
  assign rsp_pop = host_rd && (host_addr == ADR_RSP);
  assign sts_pop = host_rd && (host_addr == ADR_STS);

  mbx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (host_wdata),
    .q_read     (rsp_pop || sts_pop),
    .state_we   (state_we),
    .state_val  (state_val),
    .abort_ack  (abort_ack),
    .state_q    (state_q),
    .err_q      (err_q),
    .abort_q    (abort_q),
    .dacc_q     (dacc_q),
    .ien_q      (ien_q),
    .irq_q      (irq_q),
    .dma_now_q  (dma_now),
    .dma_trig_q (dma_trig),
    .flush      (flush),
    .going_idle (going_idle)
  );

  mbx_cmd_buffer #(.DEPTH(CMD_DEPTH)) u_cmdbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd_wr),
    .wr_data (host_wdata),
    .clear   (going_idle),
    .rd_addr (cmd_raddr),
    .rd_data (cmd_rdata),
    .count   (cmd_count)
  );

  mbx_byte_fifo #(.DEPTH(RSP_DEPTH), .W(8)) u_rspq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rsp_valid),
    .in_data  (rsp_data),
    .in_ready (rsp_ready),
    .pop      (rsp_pop),
    .flush    (flush),
    .head     (rsp_head),
    .count    (rsp_cnt)
  );

  mbx_byte_fifo #(.DEPTH(STS_DEPTH), .W(8)) u_stsq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (sts_valid),
    .in_data  (sts_data),
    .in_ready (sts_ready),
    .pop      (sts_pop),
    .flush    (flush),
    .head     (sts_head),
    .count    (sts_cnt)
  );

  assign status_byte = {(rsp_cnt != '0), (sts_cnt != '0), state_q,
                        err_q, abort_q, dacc_q, (state_q == ST_BUSY)};

  always_comb begin
    case (host_addr)
      ADR_ID:   host_rdata = irq_q ? (ID_BYTE & 8'h7F) : ID_BYTE;
      ADR_CTRL: host_rdata = status_byte;
      ADR_RSP:  host_rdata = rsp_head;
      ADR_STS:  host_rdata = sts_head;
      default:  host_rdata = 8'h00;
    endcase
  end

  assign irq_n         = !irq_q;
  assign cmd_pending   = (state_q == ST_BUSY);
  assign abort_pending = abort_q;
endmodule

// File: rtl/cmd_mailbox_checker.sv
module cmd_mailbox_checker #(
  parameter int CMD_DEPTH = 256,
  parameter int RSP_CW    = 5,
  parameter int STS_CW    = 5,
  localparam int CMD_AW   = $clog2(CMD_DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        host_addr,
  input logic              host_wr,
  input logic [7:0]        host_wdata,
  input logic              state_we,
  input logic              abort_ack,
  input logic              irq_n,
  input logic [1:0]        state_q,
  input logic              err_q,
  input logic              abort_q,
  input logic              ien_q,
  input logic              flush,
  input logic [RSP_CW-1:0] rsp_cnt,
  input logic [STS_CW-1:0] sts_cnt,
  input logic [CMD_AW:0]   cmd_count
);
  logic ctl;
  assign ctl = host_wr && (host_addr == 3'd1);

  a_r3_cmd_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_count <= (CMD_AW+1)'(CMD_DEPTH));

  a_r4_push_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && host_wdata[0] && state_q == 2'b00 && !state_we && !abort_ack)
    |=> (state_q == 2'b01));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(ctl && host_wdata[3])) |=> err_q);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rsp_cnt == '0 && sts_cnt == '0));

  a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && abort_ack && !(ctl && host_wdata[2]))
    |=> (state_q == 2'b00 && !abort_q));

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ien_q);
endmodule

bind cmd_mailbox cmd_mailbox_checker #(
  .CMD_DEPTH (CMD_DEPTH),
  .RSP_CW    (RSP_CW),
  .STS_CW    (STS_CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .state_we   (state_we),
  .abort_ack  (abort_ack),
  .irq_n      (irq_n),
  .state_q    (state_q),
  .err_q      (err_q),
  .abort_q    (abort_q),
  .ien_q      (ien_q),
  .flush      (flush),
  .rsp_cnt    (rsp_cnt),
  .sts_cnt    (sts_cnt),
  .cmd_count  (cmd_count)
);

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
  localparam int QD = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       irq_n;
  logic [7:0] cmd_raddr = '0, cmd_rdata;
  logic [8:0] cmd_count;
  logic       cmd_pending, abort_pending;
  logic       rsp_valid = 1'b0, rsp_ready;
  logic [7:0] rsp_data = '0;
  logic       sts_valid = 1'b0, sts_ready;
  logic [7:0] sts_data = '0;
  logic       state_we = 1'b0, abort_ack = 1'b0;
  logic [1:0] state_val = '0;
  logic       dma_now, dma_trig;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmd_mailbox u_cmd_mailbox (
    .clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .irq_n, .cmd_raddr, .cmd_rdata, .cmd_count, .cmd_pending, .abort_pending,
    .rsp_valid, .rsp_data, .rsp_ready, .sts_valid, .sts_data, .sts_ready,
    .state_we, .state_val, .abort_ack, .dma_now, .dma_trig
  );

  // ops: 0 host write, 1 host read+check, 2 push rsp, 3 push sts,
  //      4 set state, 5 abort ack, 6 check cmd_count, 7 check irq_n
  // entry = {req, op, addr, data, expected}
  localparam int NV = 41;
  localparam logic [31:0] VEC [NV] = '{
    {4'd1, 4'd1, 4'd0, 8'h00, 8'hC9},  // R1 id
    {4'd1, 4'd1, 4'd1, 8'h00, 8'h00},  // R1 status
    {4'd3, 4'd0, 4'd2, 8'h11, 8'h00},  // R3
    {4'd3, 4'd0, 4'd2, 8'h22, 8'h00},  // R3
    {4'd3, 4'd0, 4'd2, 8'h33, 8'h00},  // R3
    {4'd3, 4'd6, 4'd0, 8'h00, 8'h03},  // R3 count
    {4'd4, 4'd0, 4'd1, 8'h21, 8'h00},  // R4 start + irq enable
    {4'd4, 4'd1, 4'd1, 8'h00, 8'h11},  // R4 busy
    {4'd3, 4'd0, 4'd2, 8'h44, 8'h00},  // R3 dropped outside idle
    {4'd3, 4'd6, 4'd0, 8'h00, 8'h03},  // R3
    {4'd5, 4'd0, 4'd1, 8'h21, 8'h00},  // R5 start while busy
    {4'd5, 4'd1, 4'd1, 8'h00, 8'h19},  // R5 error set
    {4'd6, 4'd4, 4'd0, 8'h03, 8'h00},  // R6 data more
    {4'd7, 4'd2, 4'd0, 8'hA1, 8'h00},  // R7
    {4'd7, 4'd2, 4'd0, 8'hA2, 8'h00},  // R7
    {4'd7, 4'd3, 4'd0, 8'h5A, 8'h00},  // R7
    {4'd10, 4'd7, 4'd0, 8'h00, 8'h00}, // R10 irq low
    {4'd2, 4'd1, 4'd0, 8'h00, 8'h49},  // R2
    {4'd6, 4'd1, 4'd1, 8'h00, 8'hF8},  // R6 status
    {4'd7, 4'd1, 4'd3, 8'h00, 8'hA1},  // R7 pop
    {4'd10, 4'd7, 4'd0, 8'h00, 8'h01}, // R10 cleared by read
    {4'd2, 4'd1, 4'd0, 8'h00, 8'hC9},  // R2
    {4'd7, 4'd1, 4'd4, 8'h00, 8'h5A},  // R7
    {4'd7, 4'd1, 4'd4, 8'h00, 8'h00},  // R7 empty
    {4'd7, 4'd1, 4'd1, 8'h00, 8'hB8},  // R7 flags
    {4'd5, 4'd0, 4'd1, 8'h08, 8'h00},  // R5 clear
    {4'd5, 4'd1, 4'd1, 8'h00, 8'hB0},  // R5
    {4'd8, 4'd0, 4'd1, 8'h02, 8'h00},  // R8 accept
    {4'd8, 4'd1, 4'd1, 8'h00, 8'h32},  // R8
    {4'd8, 4'd1, 4'd3, 8'h00, 8'h00},  // R8 flushed
    {4'd6, 4'd4, 4'd0, 8'h00, 8'h00},  // R6 to idle
    {4'd6, 4'd1, 4'd1, 8'h00, 8'h00},  // R6
    {4'd6, 4'd6, 4'd0, 8'h00, 8'h00},  // R6 count cleared
    {4'd8, 4'd0, 4'd1, 8'h02, 8'h00},  // R8 accept in idle
    {4'd8, 4'd1, 4'd1, 8'h00, 8'h00},  // R8 no effect
    {4'd9, 4'd0, 4'd1, 8'h04, 8'h00},  // R9 abort
    {4'd9, 4'd1, 4'd1, 8'h00, 8'h04},  // R9
    {4'd9, 4'd5, 4'd0, 8'h00, 8'h00},  // R9 ack
    {4'd9, 4'd1, 4'd1, 8'h00, 8'h00},  // R9
    {4'd12, 4'd1, 4'd5, 8'h00, 8'h00}, // R12
    {4'd12, 4'd1, 4'd2, 8'h00, 8'h00}  // R12
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic setst(input logic [1:0] v);
    @(negedge clk); state_val = v; state_we = 1'b1;
    @(negedge clk); state_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); abort_ack = 1'b1;
    @(negedge clk); abort_ack = 1'b0;
  endtask

  task automatic push_rsp(input logic [7:0] d, input string tag);
    @(negedge clk); rsp_valid = 1'b1; rsp_data = d;
    #1 chk(tag, {15'd0, rsp_ready}, 16'd1);
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  task automatic push_sts(input logic [7:0] d, input string tag);
    @(negedge clk); sts_valid = 1'b1; sts_data = d;
    #1 chk(tag, {15'd0, sts_ready}, 16'd1);
    @(negedge clk); sts_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    chk("R1 irq_n", {15'd0, irq_n}, 16'd1);
    chk("R1 rsp_ready", {15'd0, rsp_ready}, 16'd1);
    chk("R1 sts_ready", {15'd0, sts_ready}, 16'd1);
    chk("R1 pend", {14'd0, cmd_pending, abort_pending}, 16'd0);
    chk("R1 dma", {14'd0, dma_now, dma_trig}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq, op;
      logic [7:0] a, d, e;
      string tag;
      {rq, op, a[3:0], d, e} = VEC[i];
      a[7:4] = '0;
      tag = $sformatf("R%0d vec %0d", rq, i);
      case (op)
        4'd0: hwrite(a[2:0], d);
        4'd1: begin hread(a[2:0], rd); chk(tag, {8'd0, rd}, {8'd0, e}); end
        4'd2: push_rsp(d, tag);
        4'd3: push_sts(d, tag);
        4'd4: setst(d[1:0]);
        4'd5: ack();
        4'd6: begin @(negedge clk); chk(tag, {7'd0, cmd_count}, {8'd0, e}); end
        default: begin @(negedge clk); chk(tag, {15'd0, irq_n}, {15'd0, e[0]}); end
      endcase
    end

    // R3 capacity and stored order
    for (int i = 0; i < 260; i++) hwrite(3'd2, 8'(i) ^ 8'h5A);
    @(negedge clk);
    chk("R3 count cap", {7'd0, cmd_count}, 16'd256);
    cmd_raddr = 8'd0;   #1 chk("R3 byte0", {8'd0, cmd_rdata}, 16'h005A);
    cmd_raddr = 8'd255; #1 chk("R3 byte255", {8'd0, cmd_rdata}, 16'h00A5);

    // R11 immediate DMA latched on start, R9/R6 released by abort
    hwrite(3'd1, 8'h81);
    @(negedge clk);
    chk("R11 dma_now", {14'd0, dma_now, dma_trig}, 16'd2);
    chk("R4 cmd_pending", {15'd0, cmd_pending}, 16'd1);
    hwrite(3'd1, 8'h04);
    @(negedge clk);
    chk("R9 abort_pending", {15'd0, abort_pending}, 16'd1);
    ack();
    @(negedge clk);
    chk("R9 after ack", {14'd0, abort_pending, cmd_pending}, 16'd0);
    chk("R11 released", {14'd0, dma_now, dma_trig}, 16'd0);
    chk("R6 count cleared", {7'd0, cmd_count}, 16'd0);

    // R11 trigger-mode flag
    hwrite(3'd1, 8'h41);
    @(negedge clk);
    chk("R11 dma_trig", {14'd0, dma_now, dma_trig}, 16'd1);
    setst(2'b10);
    setst(2'b00);
    @(negedge clk);
    chk("R11 trig released", {14'd0, dma_now, dma_trig}, 16'd0);

    // R5 start and clear in one write outside idle: error wins
    hwrite(3'd1, 8'h01);
    hwrite(3'd1, 8'h09);
    hread(3'd1, rd); chk("R5 set wins", {8'd0, rd}, 16'h0019);
    hwrite(3'd1, 8'h08);
    hread(3'd1, rd); chk("R5 cleared", {8'd0, rd}, 16'h0011);
    setst(2'b00);

    // R7 full queue back-pressure and order
    setst(2'b10);
    for (int i = 0; i < QD; i++) push_rsp(8'h30 + 8'(i), "R7 fill");
    @(negedge clk); rsp_valid = 1'b1; rsp_data = 8'hEE;
    #1 chk("R7 ready low full", {15'd0, rsp_ready}, 16'd0);
    @(negedge clk); rsp_valid = 1'b0;
    for (int i = 0; i < QD; i++) begin
      hread(3'd3, rd); chk("R7 order", {8'd0, rd}, {8'd0, 8'h30 + 8'(i)});
    end
    hread(3'd3, rd); chk("R7 empty read", {8'd0, rd}, 16'h0000);

    // R8 accept write and response push in the same cycle
    @(negedge clk);
    host_addr = 3'd1; host_wdata = 8'h02; host_wr = 1'b1;
    rsp_valid = 1'b1; rsp_data = 8'h77;
    #1 chk("R8 ready low in flush", {15'd0, rsp_ready}, 16'd0);
    @(negedge clk); host_wr = 1'b0;
    #1 chk("R7 ready back", {15'd0, rsp_ready}, 16'd1);
    @(negedge clk); rsp_valid = 1'b0;
    hread(3'd1, rd); chk("R8 status after overlap", {8'd0, rd}, 16'h00A2);
    hread(3'd3, rd); chk("R8 surviving byte", {8'd0, rd}, 16'h0077);
    hread(3'd3, rd); chk("R8 then empty", {8'd0, rd}, 16'h0000);
    setst(2'b00);

    // R8 status queue also emptied
    setst(2'b11);
    push_sts(8'h12, "R8 sts push");
    hwrite(3'd1, 8'h02);
    hread(3'd1, rd); chk("R8 sts flushed", {8'd0, rd}, 16'h0032);
    hread(3'd4, rd); chk("R8 sts empty", {8'd0, rd}, 16'h0000);
    setst(2'b00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule